// File: doc/BRIEF.md
# Buffered Synchronous Serial Transmitter

This block sends bytes from a small host-loaded buffer onto a serial data pin, least significant bit first. A shift clock times each bit. The clock either comes from an internal generator or arrives on an external clock pin. The host uses a simple register port. It fills the buffer words, selects the clock source, sets the run bit, and can abort a transfer through an inhibit bit.

Each time the buffer contents move into the shifter, the block pulses a buffer-empty interrupt. This tells the host that the buffer can be refilled for the next load. The host ends a stream gracefully by clearing the run bit, usually in its interrupt handler. The current load then finishes, the busy output drops, and the shift-end output pulses.

The two clock sources differ when the buffer is not refilled in time:
- With the internal clock, the generator stops and waits for the host.
- With an external clock, the stale buffer contents go out once more as a dummy load, and then the operation ends.

Top module: `sst_tx`

## Requirements
- R1: After reset, sdo=1, sclkOut=1, busy=0, irqEmpty=0 and shiftEnd=0.
- R2: Register map:
  - Address 0 is control. Write bit0 is run, bit1 is inhibit, bit2 is external clock select. Read bit7 is busy, bit2 is clock select, bit0 is run.
  - Address 1 holds the word count minus one in bits [1:0].
  - Addresses 4..7 are buffer words 0..3.
  - A write to the buffer word at index (count-1) marks the buffer full.
- R3: Words leave in index order, each least significant bit first. One bit is shifted per shift clock, and sdo is valid at each rising sclkOut edge.
- R4: busy rises once the run bit is set and the buffer is full. It stays high until the whole transfer has completed.
- R5: irqEmpty pulses for exactly one cycle for each host-filled load moved into the shifter.
- R6: When the run bit is cleared during a load, that load completes. Then busy falls and shiftEnd pulses for one cycle.
- R7: A control write with inhibit=1 drops busy at the clock edge that takes the write. It returns sdo to 1 and sclkOut to idle high, clears the run bit, and produces no shiftEnd.
- R8: In external mode, bits change on synchronised falling edges of extSclk. Bits are counted on synchronised rising edges.
- R9: In external mode, if the buffer is not refilled by the end of a load, the stale buffer is sent once more without irqEmpty. The operation then ends with shiftEnd, and the run bit reads 0.
- R10: In internal mode, if the buffer is not refilled by the end of a load, sclkOut stays high and busy stays high. Shifting resumes once the buffer is full again.
- R11: Writes to the word-count register are ignored while the run bit is set.
- R12: After a bit is presented, sdo holds it until the next falling shift-clock edge, including across load boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| extSclk | input | 1 | External shift clock |
| sclkOut | output | 1 | Generated shift clock, idle high |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| shiftEnd | output | 1 | One-cycle pulse at the graceful end of a transfer |
| irqEmpty | output | 1 | One-cycle buffer-empty interrupt |

## Verification
The hardest state to reach is the external-clock dummy load. The bench must drive extSclk slowly enough to get through the two-flop synchroniser, and it must deliberately leave the buffer stale across the load boundary. It must also hold the clock high long enough to observe that sdo keeps the last bit. The bench drives extSclk by hand and samples sdo late in each low phase. It then checks that the same byte appears a second time, followed by the end of the operation. Random byte data, word counts and load counts exercise the interrupt-driven refill handshake in internal mode.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef struct packed {
    logic load;   // copy buffer into shifter, restart bit count
    logic shift;  // falling shift edge: present next bit
    logic count;  // rising shift edge: one bit done
    logic abort;  // inhibit: stop now, idle the pin
  } dpStrobe_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} txState_t;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic extSclk,
  output logic sclkOut,
  output logic genFall,
  output logic genRise,
  output logic extFall,
  output logic extRise
);
  localparam int HW = $clog2(HALF + 1);
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] cnt;
  logic sclkQ;
  logic [2:0] syncQ;
  logic wrap;

  assign wrap    = run && (cnt == LAST);
  assign genFall = wrap && sclkQ;
  assign genRise = wrap && !sclkQ;
  assign sclkOut = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      sclkQ <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      sclkQ <= 1'b1;
    end else if (wrap) begin
      cnt   <= '0;
      sclkQ <= ~sclkQ;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // two-flop synchroniser plus one history flop for edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], extSclk};
  end

  assign extFall = syncQ[2] & ~syncQ[1];
  assign extRise = ~syncQ[2] & syncQ[1];
endmodule

// File: rtl/sst_datapath.sv
module sst_datapath
  import sst_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NWORDS = 4,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]  wcMinus1,
  input  dpStrobe_t         strb,
  output logic              sdo,
  output logic              bufFull,
  output logic              lastBit
);
  localparam int SH_W = NWORDS * WORD_W;
  localparam int BC_W = $clog2(SH_W);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(NWORDS);

  logic [WORD_W-1:0] bufMem [NWORDS];
  logic [SH_W-1:0]   shreg, loadVec;
  logic [BC_W-1:0]   bitCnt, bitLast;
  logic [ADDR_W-1:0] fullAddr;

  for (genvar i = 0; i < NWORDS; i++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bufMem[i] <= '0;
      else if (wrEn && wrAddr == BASE_A + ADDR_W'(i)) bufMem[i] <= wrData;
    end
    assign loadVec[i*WORD_W +: WORD_W] = bufMem[i];
  end

  assign fullAddr = BASE_A + ADDR_W'(wcMinus1);
  assign bitLast  = BC_W'((32'(wcMinus1) + 1) * WORD_W - 1);
  assign lastBit  = (bitCnt == bitLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           bufFull <= 1'b0;
    else if (wrEn && wrAddr == fullAddr) bufFull <= 1'b1;
    else if (strb.load)                  bufFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg  <= '0;
      bitCnt <= '0;
      sdo    <= 1'b1;
    end else begin
      if (strb.load)       shreg <= loadVec;
      else if (strb.shift) shreg <= shreg >> 1;

      if (strb.load || strb.abort) bitCnt <= '0;
      else if (strb.count)         bitCnt <= bitCnt + 1'b1;

      if (strb.abort)      sdo <= 1'b1;
      else if (strb.shift) sdo <= shreg[0];
    end
  end

  // R12: the pin moves only on a falling shift edge or an abort
  assert_sdo_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shift || strb.abort) |=> $stable(sdo));
endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              genFall,
  input  logic              genRise,
  input  logic              extFall,
  input  logic              extRise,
  input  logic              bufFull,
  input  logic              lastBit,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  wcMinus1,
  output logic              genRun,
  output logic              startQ,
  output logic              extQ,
  output logic              busy,
  output logic              irqEmpty,
  output logic              shiftEnd
);
  txState_t state, nxt;
  logic ctrlWr, inhibitWr, cntWr, fallT, riseT;
  logic dummyQ, endNow, setDummy, clrStart, realLoad;

  assign ctrlWr    = wrEn && (wrAddr == '0);
  assign inhibitWr = ctrlWr && wrData[1];
  assign cntWr     = wrEn && (wrAddr == ADDR_W'(1));
  assign fallT     = (state == S_RUN) && (extQ ? extFall : genFall);
  assign riseT     = (state == S_RUN) && (extQ ? extRise : genRise);
  assign busy      = (state != S_IDLE);
  assign genRun    = (state == S_RUN) && !extQ;

  always_comb begin
    nxt = state; strb = '0;
    endNow = 1'b0; setDummy = 1'b0; clrStart = 1'b0; realLoad = 1'b0;
    if (inhibitWr) begin
      strb.abort = 1'b1;
      nxt = S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (startQ && bufFull) begin
          strb.load = 1'b1; realLoad = 1'b1; nxt = S_RUN;
        end
        S_RUN: begin
          strb.shift = fallT;
          strb.count = riseT;
          if (riseT && lastBit) begin
            if (dummyQ || !startQ) begin
              endNow = 1'b1; clrStart = dummyQ; nxt = S_IDLE;
            end else if (bufFull) begin
              strb.load = 1'b1; realLoad = 1'b1;
            end else if (extQ) begin
              strb.load = 1'b1; setDummy = 1'b1;
            end else begin
              nxt = S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (!startQ) begin
            endNow = 1'b1; nxt = S_IDLE;
          end else if (bufFull) begin
            strb.load = 1'b1; realLoad = 1'b1; nxt = S_RUN;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; startQ <= 1'b0; extQ <= 1'b0; wcMinus1 <= '0;
      dummyQ <= 1'b0; irqEmpty <= 1'b0; shiftEnd <= 1'b0;
    end else begin
      state    <= nxt;
      irqEmpty <= realLoad;
      shiftEnd <= endNow;
      if (ctrlWr) begin
        startQ <= wrData[0] && !wrData[1];
        extQ   <= wrData[2];
      end else if (clrStart) begin
        startQ <= 1'b0;
      end
      if (cntWr && !startQ) wcMinus1 <= wrData[CNT_W-1:0];
      if (setDummy)                        dummyQ <= 1'b1;
      else if (realLoad || nxt == S_IDLE)  dummyQ <= 1'b0;
    end
  end

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    inhibitWr |=> !busy && !shiftEnd);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqEmpty |=> !irqEmpty);
  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    shiftEnd |-> !busy);
  assert_busy_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> shiftEnd || $past(inhibitWr));
  assert_count_lock_R11: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && cntWr) |=> $stable(wcMinus1));
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NWORDS = 4,
  parameter int HALF   = 2,
  localparam int ADDR_W = $clog2(2 * NWORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic              extSclk,
  output logic              sclkOut,
  output logic              sdo,
  output logic              busy,
  output logic              shiftEnd,
  output logic              irqEmpty
);
  localparam int CNT_W = $clog2(NWORDS);

  dpStrobe_t        strb;
  logic [CNT_W-1:0] wcMinus1;
  logic genRun, genFall, genRise, extFall, extRise;
  logic bufFull, lastBit, startQ, extQ;

  sst_clkgen #(.HALF(HALF)) u_clk (
    .clk, .rstN, .run(genRun), .extSclk, .sclkOut,
    .genFall, .genRise, .extFall, .extRise);

  sst_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .genFall, .genRise, .extFall,
    .extRise, .bufFull, .lastBit, .strb, .wcMinus1, .genRun, .startQ,
    .extQ, .busy, .irqEmpty, .shiftEnd);

  sst_datapath #(.WORD_W(WORD_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .wcMinus1, .strb,
    .sdo, .bufFull, .lastBit);

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) begin
      rdData[WORD_W-1] = busy;
      rdData[2]        = extQ;
      rdData[0]        = startQ;
    end else if (rdAddr == ADDR_W'(1)) begin
      rdData[CNT_W-1:0] = wcMinus1;
    end
  end
endmodule

// File: tb/sst_tx_test.sv
module sst_tx_test;
  logic clk = 0, rstN = 0, wrEn = 0, extSclk = 1;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic sclkOut, sdo, busy, shiftEnd, irqEmpty;

  int checks = 0, fails = 0, cyc = 0, irqCnt = 0, endCnt = 0, capN = 0, expN = 0;
  logic [7:0] expWords [32];
  logic capBits [256];

  sst_tx uut (.clk, .rstN, .wrEn, .wrAddr, .wrData, .rdAddr, .rdData,
              .extSclk, .sclkOut, .sdo, .busy, .shiftEnd, .irqEmpty);

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge sclkOut) if (capN < 256) begin capBits[capN] = sdo; capN++; end
  always @(negedge clk) begin
    if (rstN && irqEmpty) irqCnt++;
    if (rstN && shiftEnd) endCnt++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary(); $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rdAddr = a; #1 d = rdData;
  endtask

  function automatic logic [7:0] capWord(int w);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = capBits[w*8 + b];
    return v;
  endfunction

  task automatic fill(int wc);
    for (int w = 0; w <= wc; w++) begin
      logic [7:0] d = 8'($urandom);
      wr(3'(4 + w), d);
      expWords[expN] = d; expN++;
    end
  endtask

  task automatic waitIrq();
    @(negedge clk); while (!irqEmpty) @(negedge clk);
  endtask

  task automatic waitEnd();
    @(negedge clk); while (!shiftEnd) @(negedge clk);
  endtask

  task automatic cmpStream(string req);
    chk({req, " bit count"}, 32'(capN), 32'(expN * 8));
    for (int w = 0; w < expN; w++) chk({req, " word"}, 32'(capWord(w)), 32'(expWords[w]));
  endtask

  task automatic extBit(output logic b);
    extSclk = 0; repeat (8) @(negedge clk); b = sdo;
    extSclk = 1; repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    logic b;
    int wc, loads, i0, e0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sdo", 32'(sdo), 1); chk("R1 sclkOut", 32'(sclkOut), 1);
    chk("R1 busy", 32'(busy), 0); chk("R1 irq", 32'(irqEmpty), 0);
    chk("R1 end", 32'(shiftEnd), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R3 R5 R6 R11: random interrupt-driven streams, internal clock
    for (int it = 0; it < 4; it++) begin
      wc = $urandom_range(0, 3); loads = $urandom_range(1, 3);
      wr(1, 8'(wc));
      capN = 0; expN = 0; i0 = irqCnt; e0 = endCnt;
      fill(wc);
      wr(0, 8'h01);
      waitIrq();
      chk("R4 busy during", 32'(busy), 1);
      rd(0, r); chk("R2 status busy bit7", 32'(r[7]), 1);
      if (it == 0) wr(1, 8'(wc ^ 1));  // R11 locked write
      for (int l = 1; l < loads; l++) begin fill(wc); waitIrq(); end
      wr(0, 8'h00);
      waitEnd();
      chk("R6 busy low at end", 32'(busy), 0);
      repeat (4) @(negedge clk);
      cmpStream("R3 stream");
      chk("R5 irq count", 32'(irqCnt - i0), 32'(loads));
      chk("R6 end count", 32'(endCnt - e0), 1);
      rd(1, r); chk("R11 count kept", 32'(r[1:0]), 32'(wc));
    end

    // R10: internal stall when buffer not refilled
    wr(1, 0); capN = 0; expN = 0; e0 = endCnt;
    fill(0); wr(0, 8'h01); waitIrq();
    repeat (80) @(negedge clk);
    chk("R10 bits before stall", 32'(capN), 8);
    i0 = capN;
    repeat (40) @(negedge clk);
    chk("R10 no clock in stall", 32'(capN), 32'(i0));
    chk("R10 sclk high", 32'(sclkOut), 1);
    chk("R10 busy held", 32'(busy), 1);
    chk("R12 sdo holds last bit", 32'(sdo), 32'(expWords[0][7]));
    fill(0); waitIrq(); wr(0, 8'h00); waitEnd();
    repeat (4) @(negedge clk);
    cmpStream("R10 resume stream");
    chk("R10 end count", 32'(endCnt - e0), 1);

    // R7: inhibit abort mid-stream
    wr(1, 1); expN = 0; fill(1); e0 = endCnt;
    wr(0, 8'h01);
    repeat (20) @(negedge clk);
    chk("R7 busy before abort", 32'(busy), 1);
    wr(0, 8'h02);
    chk("R7 busy dropped", 32'(busy), 0);
    chk("R7 sdo idle", 32'(sdo), 1);
    repeat (40) @(negedge clk);
    chk("R7 no shiftEnd", 32'(endCnt - e0), 0);
    chk("R7 sclk idle", 32'(sclkOut), 1);
    rd(0, r); chk("R7 run cleared", 32'(r[0]), 0);

    // R8 R9 R12: external clock, one word, no refill -> dummy then end
    wr(1, 0); expN = 0; fill(0); i0 = irqCnt; e0 = endCnt;
    wr(0, 8'h05);
    repeat (4) @(negedge clk);
    chk("R8 busy ext", 32'(busy), 1);
    chk("R12 sdo before first fall", 32'(sdo), 1);
    for (int k = 0; k < 8; k++) begin
      extBit(b); chk("R8 ext bit", 32'(b), 32'(expWords[0][k]));
    end
    repeat (30) @(negedge clk);
    chk("R12 sdo holds across load", 32'(sdo), 32'(expWords[0][7]));
    chk("R9 still busy for dummy", 32'(busy), 1);
    for (int k = 0; k < 8; k++) begin
      extBit(b); chk("R9 dummy bit", 32'(b), 32'(expWords[0][k]));
    end
    repeat (10) @(negedge clk);
    chk("R9 busy low", 32'(busy), 0);
    chk("R9 shiftEnd once", 32'(endCnt - e0), 1);
    chk("R9 single irq", 32'(irqCnt - i0), 1);
    rd(0, r); chk("R9 run cleared", 32'(r[0]), 0);
    chk("R2 ext select readback", 32'(r[2]), 1);

    summary();
    $finish;
  end
endmodule